// File: doc/BRIEF.md
# Shared Interrupt/Reset Pin Agent

This block sits on the module side of a single active-low, open-drain wire that two parties share. The module pulls the wire low briefly to tell the host that something needs its attention. The host pulls the same wire low for a long time to ask the module to reset. The block never drives the wire high. It only enables a pull-down, and an external resistor provides the high level. The only thing that separates the two meanings is how long the line stays low.

Status conditions arrive as level inputs. A rising condition is latched into a sticky flag, and a host read of the flags clears them. Each flag has a mask bit that can stop it from raising an interrupt. Any unmasked flag that is newly pending produces one fixed-width pulse on the wire. After the pulse, the wire is released for a minimum high gap. While the wire is released, the block measures how long it has been low, using a two-stage synchronized copy of the pin. A long enough low period starts an internal reset. When the host lets go of the wire, an initialization interval runs. At the end of that interval the data-not-ready status clears and one interrupt pulse is issued. Power-on reset enters the same initialization interval.

All durations are given in microseconds and converted to clock cycles using the clock frequency in MHz. The block has no streaming data path, so every pin is a plain level or strobe without a handshake.

Top module: `intrst_pin_agent`

## Requirements
- R1: The pin is driven only through `pin_pull_o`. When it is 1, the pin is pulled low. When it is 0, the pin is released. `pin_pull_o` is 0 in every cycle in which `mod_reset_o` is 1.
- R2: Every interrupt pulse keeps `pin_pull_o` high for exactly INT_US*CLK_MHZ consecutive cycles, and then the pin is released (pulse mode). The width must lie between 5 µs and 50 µs.
- R3: Outside reset and initialization, a 0-to-1 change on `cond_i[i]` sets `flags_o[i]` at the next clock edge. The flag stays set after the condition falls.
- R4: A cycle with `flag_rd_i`=1 clears every bit of `flags_o` at the next edge. A condition that rises in that same cycle still sets its flag.
- R5: A newly latched, unmasked flag starts a pulse one edge after the flag appears, provided the block is idle and the pin is seen high.
- R6: Flags that are pending when a pulse starts are served by that single pulse. A flag that becomes pending during a pulse or during its gap produces exactly one more pulse. That pulse comes after the pin has been released for GAP_US*CLK_MHZ cycles.
- R7: A flag whose `mask_i` bit is 1 still latches but raises no pulse. If it is still pending when the mask bit returns to 0, a pulse is issued.
- R8: In the idle state, the synchronized pin can stay low for RST_US*CLK_MHZ consecutive cycles without the block pulling it. When that happens, `mod_reset_o` and `not_ready_o` go to 1 and the flags clear. They stay that way until the pin is seen high again.
- R9: After power-on reset, or after the pin returns high from a host reset, `not_ready_o` stays at 1 for INIT_US*CLK_MHZ cycles. It then drops to 0 in the same cycle that an interrupt pulse begins. Flags stay clear while `not_ready_o` is 1.
- R10: A host low period shorter than the reset time has no effect on the flags or on the reset state. No pulse starts while the pin is seen low. A pulse that was held back starts once the pin is seen high.
- R11: Low time is not counted while the block drives its own pulse or during the following gap. A host low period that overlaps a pulse is timed only from the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pin_i | input | 1 | Sensed level of the shared wire (asynchronous) |
| pin_pull_o | output | 1 | Pull-down enable for the shared wire |
| cond_i | input | N | Raw status conditions |
| mask_i | input | N | Per-flag interrupt inhibit |
| flag_rd_i | input | 1 | Host read strobe, clears all flags |
| flags_o | output | N | Sticky flag bits |
| not_ready_o | output | 1 | Data-not-ready status |
| mod_reset_o | output | 1 | Internal reset request while the host holds reset |

## Verification
The hardest situation to reach from the ports is a host reset attempt that overlaps the block's own pulse. In that case the sensed low level is partly the block's own doing, and it must not be counted. The stimulus waits until the pull-down enable is seen rising. It then holds the host side low for longer than the pulse and gap combined, but for less than pulse plus gap plus the reset time. The expected outcome is no reset, with flags and status unchanged. A second sequence defers a pulse behind a short host low period. A third raises a new flag partway through a pulse, which checks the follow-up pulse timing after the gap.

// File: rtl/ira_pkg.sv
package ira_pkg;
  typedef enum logic [2:0] {
    PH_INIT  = 3'd0,
    PH_IDLE  = 3'd1,
    PH_PULSE = 3'd2,
    PH_GAP   = 3'd3,
    PH_HRST  = 3'd4
  } phase_e;
endpackage

// File: rtl/ira_sync2.sv
module ira_sync2 #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ira_flag_bank.sv
module ira_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_clr_i,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] mask_i,
  input  logic         rd_clr_i,
  input  logic         take_i,
  output logic [N-1:0] flags_o,
  output logic         req_o
);
  logic [N-1:0] cond_q, flags_q, pend_q;
  logic [N-1:0] rise, flags_d, pend_d;

  assign rise = cond_i & ~cond_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      always_comb begin
        if (hold_clr_i) begin
          flags_d[g] = 1'b0;
          pend_d[g]  = 1'b0;
        end else begin
          flags_d[g] = (flags_q[g] & ~rd_clr_i) | rise[g];
          pend_d[g]  = (pend_q[g] & ~rd_clr_i & ~(take_i & ~mask_i[g])) | rise[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q  <= '0;
      flags_q <= '0;
      pend_q  <= '0;
    end else begin
      cond_q  <= cond_i;
      flags_q <= flags_d;
      pend_q  <= pend_d;
    end
  end

  assign flags_o = flags_q;
  assign req_o   = |(pend_q & ~mask_i);
endmodule

// File: rtl/ira_sequencer.sv
module ira_sequencer
  import ira_pkg::*;
#(
  parameter int unsigned INIT_CYC  = 30,
  parameter int unsigned PULSE_CYC = 8,
  parameter int unsigned GAP_CYC   = 4,
  parameter int unsigned RST_CYC   = 40
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_s_i,
  input  logic   req_i,
  output phase_e phase_o,
  output logic   take_o
);
  localparam int unsigned M01  = (INIT_CYC > PULSE_CYC) ? INIT_CYC : PULSE_CYC;
  localparam int unsigned M23  = (GAP_CYC > RST_CYC) ? GAP_CYC : RST_CYC;
  localparam int unsigned MAXC = (M01 > M23) ? M01 : M23;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q + CW'(1);
    take_o = 1'b0;
    unique case (ph_q)
      PH_INIT: begin
        if (cnt_q == CW'(INIT_CYC - 1)) begin
          ph_d  = PH_PULSE;
          cnt_d = '0;
        end
      end
      PH_IDLE: begin
        if (!line_s_i) begin
          if (cnt_q == CW'(RST_CYC - 1)) begin
            ph_d  = PH_HRST;
            cnt_d = '0;
          end
        end else begin
          cnt_d = '0;
          if (req_i) begin
            take_o = 1'b1;
            ph_d   = PH_PULSE;
          end
        end
      end
      PH_PULSE: begin
        if (cnt_q == CW'(PULSE_CYC - 1)) begin
          ph_d  = PH_GAP;
          cnt_d = '0;
        end
      end
      PH_GAP: begin
        if (cnt_q == CW'(GAP_CYC - 1)) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      end
      PH_HRST: begin
        cnt_d = '0;
        if (line_s_i) ph_d = PH_INIT;
      end
      default: begin
        ph_d  = PH_INIT;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_INIT;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/intrst_pin_agent.sv
module intrst_pin_agent
  import ira_pkg::*;
#(
  parameter int unsigned N        = 4,
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned INT_US   = 20,
  parameter int unsigned GAP_US   = 10,
  parameter int unsigned RST_US   = 25000,
  parameter int unsigned INIT_US  = 1000000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  output logic         pin_pull_o,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] mask_i,
  input  logic         flag_rd_i,
  output logic [N-1:0] flags_o,
  output logic         not_ready_o,
  output logic         mod_reset_o
);
  localparam int unsigned PULSE_CYC = INT_US  * CLK_MHZ;
  localparam int unsigned GAP_CYC   = GAP_US  * CLK_MHZ;
  localparam int unsigned RST_CYC   = RST_US  * CLK_MHZ;
  localparam int unsigned INIT_CYC  = INIT_US * CLK_MHZ;

  logic   line_s, req, take, hold_clr;
  phase_e phase;

  ira_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (line_s)
  );

  ira_flag_bank #(.N(N)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_clr_i (hold_clr),
    .cond_i     (cond_i),
    .mask_i     (mask_i),
    .rd_clr_i   (flag_rd_i),
    .take_i     (take),
    .flags_o    (flags_o),
    .req_o      (req)
  );

  ira_sequencer #(
    .INIT_CYC  (INIT_CYC),
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC),
    .RST_CYC   (RST_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s_i (line_s),
    .req_i    (req),
    .phase_o  (phase),
    .take_o   (take)
  );

  assign hold_clr    = (phase == PH_INIT) || (phase == PH_HRST);
  assign pin_pull_o  = (phase == PH_PULSE);
  assign not_ready_o = hold_clr;
  assign mod_reset_o = (phase == PH_HRST);
endmodule

// File: rtl/ira_checker.sv
module ira_checker #(
  parameter int unsigned N       = 4,
  parameter int unsigned MIN_CYC = 500,
  parameter int unsigned MAX_CYC = 5000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pin_pull_o,
  input logic [N-1:0] cond_i,
  input logic         flag_rd_i,
  input logic [N-1:0] flags_o,
  input logic         not_ready_o,
  input logic         mod_reset_o
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 0;
    else if (pin_pull_o) run_q <= run_q + 1;
    else                 run_q <= 0;
  end

  // R2: a pulse never outlasts the maximum width
  a_r2_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= MAX_CYC);

  // R2: a finished pulse lasted at least the minimum width
  a_r2_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_pull_o && run_q != 0) |-> run_q >= MIN_CYC);

  // R1: no pull while host reset is in progress
  a_r1_no_pull_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    mod_reset_o |-> (!pin_pull_o && not_ready_o));

  // R9: flags stay clear while not ready
  a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    not_ready_o |=> (flags_o == '0));

  // R6: release lasts more than one cycle after a pulse
  a_r6_gap_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_pull_o) |=> !pin_pull_o);

  // R4: after a read only same-cycle rises survive
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_i |=> ((flags_o & ~($past(cond_i) & ~$past(cond_i, 2))) == '0));
endmodule

bind intrst_pin_agent ira_checker #(
  .N       (N),
  .MIN_CYC (5 * CLK_MHZ),
  .MAX_CYC (50 * CLK_MHZ)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_pull_o  (pin_pull_o),
  .cond_i      (cond_i),
  .flag_rd_i   (flag_rd_i),
  .flags_o     (flags_o),
  .not_ready_o (not_ready_o),
  .mod_reset_o (mod_reset_o)
);

// File: tb/intrst_pin_agent_tb_top.sv
`timescale 1ns/1ps
module intrst_pin_agent_tb_top;
  localparam int N       = 4;
  localparam int CLK_MHZ = 1;
  localparam int INT_US  = 8;
  localparam int GAP_US  = 4;
  localparam int RST_US  = 40;
  localparam int INIT_US = 30;
  localparam int P_CYC   = INT_US * CLK_MHZ;
  localparam int G_CYC   = GAP_US * CLK_MHZ;
  localparam int R_CYC   = RST_US * CLK_MHZ;
  localparam int I_CYC   = INIT_US * CLK_MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic [N-1:0] cond = '0;
  logic [N-1:0] mask = '0;
  logic rd = 1'b0;
  logic pull, nr, mrst;
  logic [N-1:0] flags;
  wire pin = ~(pull | host_low);

  always #5 clk = ~clk;

  intrst_pin_agent #(
    .N(N), .CLK_MHZ(CLK_MHZ), .INT_US(INT_US), .GAP_US(GAP_US),
    .RST_US(RST_US), .INIT_US(INIT_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_pull_o(pull),
    .cond_i(cond), .mask_i(mask), .flag_rd_i(rd), .flags_o(flags),
    .not_ready_o(nr), .mod_reset_o(mrst)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R9";

  // behavioural reference: phase 0 init, 1 idle, 2 pulse, 3 gap, 4 host reset
  int m_ph, m_t;
  logic m_s1, m_s2;
  logic [N-1:0] m_cq, m_flags, m_pend, rise;
  logic pin_now, clr, take;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_s1 = 1; m_s2 = 1;
      m_cq = '0; m_flags = '0; m_pend = '0;
    end else begin
      pin_now = !((m_ph == 2) || host_low);
      rise = cond & ~m_cq;
      clr = (m_ph == 0) || (m_ph == 4);
      take = (m_ph == 1) && m_s2 && ((m_pend & ~mask) != 0);
      if (clr) begin
        m_flags = '0; m_pend = '0;
      end else begin
        if (rd) begin m_flags = '0; m_pend = '0; end
        if (take) m_pend = m_pend & mask;
        m_flags = m_flags | rise;
        m_pend = m_pend | rise;
      end
      case (m_ph)
        0: begin m_t++; if (m_t == I_CYC) begin m_ph = 2; m_t = 0; end end
        1: begin
             if (!m_s2) begin
               m_t++;
               if (m_t == R_CYC) begin m_ph = 4; m_t = 0; end
             end else begin
               m_t = 0;
               if (take) m_ph = 2;
             end
           end
        2: begin m_t++; if (m_t == P_CYC) begin m_ph = 3; m_t = 0; end end
        3: begin m_t++; if (m_t == G_CYC) begin m_ph = 1; m_t = 0; end end
        default: begin m_t = 0; if (m_s2) m_ph = 0; end
      endcase
      m_s2 = m_s1; m_s1 = pin_now;
      m_cq = cond;
    end
  end

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check({tag, " pull"},  32'(pull),  32'(m_ph == 2));
    check({tag, " nrdy"},  32'(nr),    32'((m_ph == 0) || (m_ph == 4)));
    check({tag, " mrst"},  32'(mrst),  32'(m_ph == 4));
    check({tag, " flags"}, 32'(flags), 32'(m_flags));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    logic prev;
    prev = pull;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pull && !prev) cnt++;
      prev = pull;
    end
  endtask

  task automatic pulse_width(output int w);
    int guard;
    guard = 0;
    w = 0;
    while (!pull && guard < 300) begin @(negedge clk); guard++; end
    while (pull && w < 300) begin @(negedge clk); w++; end
  endtask

  task automatic do_read();
    rd = 1'b1; tick(1); rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int w, c;
    logic seen_rst;
    tick(3);
    // R9 reset state
    check("R9 reset nrdy", 32'(nr), 32'd1);
    check("R1 reset pull", 32'(pull), 32'd0);
    rst_n = 1'b1;
    // R9 init ends with a pulse; R2 width
    tag = "R9";
    pulse_width(w);
    check("R2 init pulse width", w, P_CYC);
    check("R9 ready after init", 32'(nr), 32'd0);
    tick(G_CYC + 4);

    // R3 / R5 single flag
    tag = "R3";
    cond[0] = 1'b1; tick(1);
    check("R3 flag latched", 32'(flags), 32'h1);
    tick(1);
    check("R5 pulse started", 32'(pull), 32'd1);
    cond[0] = 1'b0;
    tick(P_CYC + G_CYC + 2);
    check("R3 flag sticky", 32'(flags[0]), 32'd1);

    // R4 read clear with concurrent rise
    tag = "R4";
    cond[3] = 1'b1; rd = 1'b1; tick(1); rd = 1'b0;
    check("R4 read keeps same-cycle rise", 32'(flags), 32'h8);
    tick(P_CYC + G_CYC + 3);
    cond = '0; do_read(); tick(2);

    // R6 two flags one pulse, then one arriving during a pulse
    tag = "R6";
    cond[1:0] = 2'b11;
    count_pulses(40, c);
    check("R6 merged flags one pulse", c, 1);
    cond = '0; tick(2);
    cond[3] = 1'b1; tick(4); cond[2] = 1'b1;
    count_pulses(60, c);
    check("R6 flag during pulse gets second pulse", c + 1, 2);
    cond = '0; do_read(); tick(2);

    // R7 masking
    tag = "R7";
    mask = 4'b0100; cond[2] = 1'b1;
    count_pulses(30, c);
    check("R7 masked flag no pulse", c, 0);
    check("R7 masked flag latched", 32'(flags[2]), 32'd1);
    mask = '0;
    count_pulses(30, c);
    check("R7 unmask releases pulse", c, 1);
    cond = '0; do_read(); tick(2);

    // R10 short host low, deferred pulse
    tag = "R10";
    cond[0] = 1'b1; tick(P_CYC + G_CYC + 4); cond[0] = 1'b0; tick(1);
    host_low = 1'b1; tick(5);
    cond[1] = 1'b1;
    count_pulses(15, c);
    check("R10 no pulse while line low", c, 0);
    host_low = 1'b0;
    count_pulses(30, c);
    check("R10 deferred pulse", c, 1);
    check("R10 flags kept", 32'(flags), 32'h3);
    check("R10 no reset", 32'(mrst | nr), 32'd0);
    cond = '0; tick(2);

    // R11 host low overlapping own pulse
    tag = "R11";
    cond[2] = 1'b1;
    while (!pull) @(negedge clk);
    host_low = 1'b1;
    seen_rst = 1'b0;
    for (int i = 0; i < P_CYC + G_CYC + R_CYC - 6; i++) begin
      @(negedge clk);
      if (mrst) seen_rst = 1'b1;
    end
    host_low = 1'b0;
    check("R11 no reset from overlapped low", 32'(seen_rst), 32'd0);
    tick(4);
    check("R11 flags intact", 32'(flags[2]), 32'd1);
    cond = '0; tick(2);

    // R8 host reset, R9 re-init
    tag = "R8";
    host_low = 1'b1;
    tick(R_CYC + 6);
    check("R8 reset asserted", 32'(mrst), 32'd1);
    check("R8 flags cleared", 32'(flags), 32'd0);
    check("R1 no pull in reset", 32'(pull), 32'd0);
    host_low = 1'b0;
    tag = "R9";
    c = 0;
    while (nr && c < 200) begin @(negedge clk); c++; end
    check("R9 pulse with ready", 32'(pull), 32'd1);
    check("R9 init length", c, I_CYC + 3);
    tick(P_CYC + G_CYC + 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule